// File: doc/BRIEF.md
# Multi-Size LRU Stack Tag Store

This block is a fully associative tag store that holds up to `NUM_BLOCKS` cache blocks in one recency stack. Entries run from most recently used at position 0 to least recently used at the far end. All valid tags are compared in parallel, so each lookup resolves in the same cycle. LRU stacks have the inclusion property: a block at recency position p would also be resident in any LRU cache of more than p blocks. The store uses this to report hit or miss for the full capacity and for a series of smaller power-of-two capacities (2, 4 and 8 blocks by default) with one lookup. Per-capacity hit and miss counters and a total access counter accumulate these results.

Each cycle the block decodes its request ports into one operation kind. The kinds are `OP_IDLE`, `OP_ACCESS` (a normal lookup that promotes), `OP_PROBE` (a lookup-only operation), `OP_FILL` (an insert into the victim entry), `OP_REFRESH` (an insert of an address that is already resident), `OP_DROP` (an invalidate that matches) and `OP_INV_MISS` (an invalidate that does not match). The decode priority is fixed: invalidate first, then insert, then access. Only the chosen operation acts at the next clock edge. Every operation returns to the decode in the next cycle, so there is no multi-cycle sequence. Lookup results are combinational. The recency stack, the valid and tag storage and the counters update at the next rising edge.

Top module: `lrus_tag_store`

## Requirements
- R1: The tag is the address with its low log2(`BLK_BYTES`) offset bits cleared (64-byte blocks by default). Two addresses that differ only in those bits match the same entry.
- R2: A normal access that hits (`acc_valid`=1, `acc_probe`=0) moves the hit block to recency position 0. The blocks that were above it each move down one position.
- R3: A lookup-only access (`acc_probe`=1) reports hit and mask like a normal access. It changes neither the recency order nor any counter.
- R4: On a hit, `hit_mask` bit i is 1 exactly when the block's recency position is below `BASE_BLOCKS`·2^i (positions below 2, 4 and 8 for bits 0, 1 and 2). On a miss, `hit_mask` is all zero.
- R5: `victim_way` is the entry at the least-recently-used end. `victim_valid` is 1 only when that entry holds a valid block, which happens only when every entry is valid.
- R6: An insert of a non-resident address writes its tag into the victim entry, marks it valid and places it at position 0.
- R7: An insert of an address that is already resident makes no second copy. It moves the existing entry to position 0 and leaves the victim unchanged.
- R8: An invalidate that matches clears the entry's valid bit, so the entry no longer matches. It also moves the entry to the least-recently-used end, where it becomes the victim.
- R9: A normal access increments `access_count`. For each capacity s it increments field s of `hit_count` on a hit there, or field s of `miss_count` otherwise. Field s occupies bits [s·`CNT_W` +: `CNT_W`]. Fields 0..`NUM_SIZES`-1 are the smaller capacities in rising order, and field `NUM_SIZES` is the full store.
- R10: When more than one request port is active in a cycle, invalidate beats insert and insert beats access. The losing requests have no effect on state or counters.
- R11: Reset clears every valid bit and every counter. It restores the recency order so that entry p sits at position p, which makes `victim_way` = `NUM_BLOCKS`-1 with `victim_valid` = 0.
- R12: `hit`, `hit_way` and `hit_mask` reflect the current address in the same cycle. The recency and counter updates appear after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request present |
| acc_probe | input | 1 | Access is lookup-only (no promotion, no counting) |
| acc_addr | input | ADDR_W | Access address |
| ins_valid | input | 1 | Insert request present |
| ins_addr | input | ADDR_W | Address to insert |
| inv_valid | input | 1 | Invalidate request present |
| inv_addr | input | ADDR_W | Address to invalidate |
| hit | output | 1 | Access address matches a valid entry |
| hit_way | output | IDX_W | Entry index of the hit |
| hit_mask | output | NUM_SIZES | Per-capacity residency of the hit block |
| victim_way | output | IDX_W | Entry at the least-recently-used end |
| victim_valid | output | 1 | Victim entry holds a valid block |
| hit_count | output | (NUM_SIZES+1)·CNT_W | Per-capacity hit counters |
| miss_count | output | (NUM_SIZES+1)·CNT_W | Per-capacity miss counters |
| access_count | output | CNT_W | Normal access counter |

## Verification
The bench targets the mask boundaries at positions 1/2, 3/4, 7/8 and at the bottom of the stack. A block at position 8 or beyond must hit with an all-zero mask. A design with an off-by-one capacity compare would set a mask bit one position too far down. A probe followed by another probe of the same block must keep the same position; a design that promoted on probes would report the wider mask on the second lookup. The bench also drives simultaneous requests, duplicate inserts and eviction after a full fill. A wrong priority would let a losing access move the counters. A missing resident check on insert would leave a stale copy and pick the wrong block to evict. A design that invalidated without sinking the entry would evict a live block in its place.

// File: rtl/lrus_pkg.sv
package lrus_pkg;

    // Operation kind chosen from the request ports each cycle.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ACCESS,
        OP_PROBE,
        OP_FILL,
        OP_REFRESH,
        OP_DROP,
        OP_INV_MISS
    } op_e;

endpackage

// File: rtl/lrus_tag_match.sv
module lrus_tag_match #(
    parameter int NUM_BLOCKS = 16,
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 6,
    parameter int TAG_W      = ADDR_W - OFF_W,
    parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [NUM_BLOCKS-1:0][TAG_W-1:0]    tags,
    input  logic [NUM_BLOCKS-1:0]               valid,
    output logic [NUM_BLOCKS-1:0]               match,
    output logic                                hit,
    output logic [IDX_W-1:0]                    way
);

    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

    logic [ADDR_W-1:0] aligned;

    assign aligned = addr & ~OFF_MASK;

    // One comparator per entry, all in parallel.
    for (genvar e = 0; e < NUM_BLOCKS; e++) begin : g_cmp
        assign match[e] = valid[e] && ({tags[e], {OFF_W{1'b0}}} == aligned);
    end

    assign hit = |match;

    // OR-encode; the match vector holds at most one set bit.
    always_comb begin
        way = '0;
        for (int e = 0; e < NUM_BLOCKS; e++) begin
            if (match[e]) begin
                way = way | IDX_W'(e);
            end
        end
    end

endmodule

// File: rtl/lrus_recency.sv
module lrus_recency #(
    parameter int NUM_BLOCKS = 16,
    parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                move_front,
    input  logic                                move_back,
    input  logic [IDX_W-1:0]                    sel_way,
    output logic [NUM_BLOCKS-1:0][IDX_W-1:0]    order,
    output logic [NUM_BLOCKS-1:0][IDX_W-1:0]    rank
);

    localparam int LAST = NUM_BLOCKS - 1;

    logic [NUM_BLOCKS-1:0][IDX_W-1:0] order_q;
    logic [NUM_BLOCKS-1:0][IDX_W-1:0] order_d;
    logic [IDX_W-1:0]                 sel_pos;
    int                               sel_i;

    // Position of each entry: inverse of the order array.
    always_comb begin
        rank = '0;
        for (int p = 0; p < NUM_BLOCKS; p++) begin
            rank[order_q[p]] = IDX_W'(p);
        end
    end

    assign sel_pos = rank[sel_way];
    assign sel_i   = int'(sel_pos);

    always_comb begin
        order_d = order_q;
        if (move_front) begin
            order_d[0] = sel_way;
            for (int p = 1; p < NUM_BLOCKS; p++) begin
                if (p <= sel_i) begin
                    order_d[p] = order_q[p-1];
                end
            end
        end else if (move_back) begin
            for (int p = 0; p < LAST; p++) begin
                if (p >= sel_i) begin
                    order_d[p] = order_q[p+1];
                end
            end
            order_d[LAST] = sel_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_BLOCKS; p++) begin
                order_q[p] <= IDX_W'(p);
            end
        end else begin
            order_q <= order_d;
        end
    end

    assign order = order_q;

endmodule

// File: rtl/lrus_stat_counters.sv
module lrus_stat_counters #(
    parameter int NUM_SIZES = 3,
    parameter int CNT_W     = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            count_en,
    input  logic                            hit_full,
    input  logic [NUM_SIZES-1:0]            mask,
    output logic [(NUM_SIZES+1)*CNT_W-1:0]  hit_count,
    output logic [(NUM_SIZES+1)*CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]                access_count
);

    logic [CNT_W-1:0] acc_q;

    for (genvar s = 0; s <= NUM_SIZES; s++) begin : g_cap
        logic             in_cap;
        logic [CNT_W-1:0] hit_q;
        logic [CNT_W-1:0] miss_q;

        if (s == NUM_SIZES) begin : g_full
            assign in_cap = hit_full;
        end else begin : g_part
            assign in_cap = mask[s];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hit_q  <= '0;
                miss_q <= '0;
            end else if (count_en) begin
                if (in_cap) begin
                    hit_q <= hit_q + CNT_W'(1);
                end else begin
                    miss_q <= miss_q + CNT_W'(1);
                end
            end
        end

        assign hit_count[s*CNT_W +: CNT_W]  = hit_q;
        assign miss_count[s*CNT_W +: CNT_W] = miss_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (count_en) begin
            acc_q <= acc_q + CNT_W'(1);
        end
    end

    assign access_count = acc_q;

endmodule

// File: rtl/lrus_tag_store.sv
module lrus_tag_store
    import lrus_pkg::*;
#(
    parameter int NUM_BLOCKS  = 16,
    parameter int ADDR_W      = 32,
    parameter int BLK_BYTES   = 64,
    parameter int BASE_BLOCKS = 2,
    parameter int NUM_SIZES   = 3,
    parameter int CNT_W       = 16,
    localparam int IDX_W      = $clog2(NUM_BLOCKS),
    localparam int OFF_W      = $clog2(BLK_BYTES),
    localparam int TAG_W      = ADDR_W - OFF_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            acc_valid,
    input  logic                            acc_probe,
    input  logic [ADDR_W-1:0]               acc_addr,
    input  logic                            ins_valid,
    input  logic [ADDR_W-1:0]               ins_addr,
    input  logic                            inv_valid,
    input  logic [ADDR_W-1:0]               inv_addr,
    output logic                            hit,
    output logic [IDX_W-1:0]                hit_way,
    output logic [NUM_SIZES-1:0]            hit_mask,
    output logic [IDX_W-1:0]                victim_way,
    output logic                            victim_valid,
    output logic [(NUM_SIZES+1)*CNT_W-1:0]  hit_count,
    output logic [(NUM_SIZES+1)*CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]                access_count
);

    // Storage
    logic [NUM_BLOCKS-1:0][TAG_W-1:0] tag_q;
    logic [NUM_BLOCKS-1:0]            valid_q;

    // Lookup results
    logic [NUM_BLOCKS-1:0] acc_match;
    logic                  acc_hit;
    logic [IDX_W-1:0]      acc_way;
    logic [ADDR_W-1:0]     upd_addr;
    logic [NUM_BLOCKS-1:0] upd_match;
    logic                  upd_hit;
    logic [IDX_W-1:0]      upd_way;

    // Recency
    logic [NUM_BLOCKS-1:0][IDX_W-1:0] order;
    logic [NUM_BLOCKS-1:0][IDX_W-1:0] rank;
    logic [IDX_W-1:0]                 acc_rank;

    // Control
    op_e              op;
    logic             move_front;
    logic             move_back;
    logic [IDX_W-1:0] sel_way;
    logic             count_en;
    logic             write_tag;
    logic             clear_valid;

    lrus_tag_match #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .ADDR_W     (ADDR_W),
        .OFF_W      (OFF_W),
        .TAG_W      (TAG_W),
        .IDX_W      (IDX_W)
    ) u_acc_match (
        .addr  (acc_addr),
        .tags  (tag_q),
        .valid (valid_q),
        .match (acc_match),
        .hit   (acc_hit),
        .way   (acc_way)
    );

    // Insert and invalidate share one comparator bank; invalidate wins.
    assign upd_addr = inv_valid ? inv_addr : ins_addr;

    lrus_tag_match #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .ADDR_W     (ADDR_W),
        .OFF_W      (OFF_W),
        .TAG_W      (TAG_W),
        .IDX_W      (IDX_W)
    ) u_upd_match (
        .addr  (upd_addr),
        .tags  (tag_q),
        .valid (valid_q),
        .match (upd_match),
        .hit   (upd_hit),
        .way   (upd_way)
    );

    lrus_recency #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDX_W      (IDX_W)
    ) u_recency (
        .clk        (clk),
        .rst_n      (rst_n),
        .move_front (move_front),
        .move_back  (move_back),
        .sel_way    (sel_way),
        .order      (order),
        .rank       (rank)
    );

    // Operation decode: fixed priority invalidate > insert > access.
    always_comb begin
        if (inv_valid) begin
            op = upd_hit ? OP_DROP : OP_INV_MISS;
        end else if (ins_valid) begin
            op = upd_hit ? OP_REFRESH : OP_FILL;
        end else if (acc_valid) begin
            op = acc_probe ? OP_PROBE : OP_ACCESS;
        end else begin
            op = OP_IDLE;
        end
    end

    // Actions per operation kind.
    always_comb begin
        move_front  = 1'b0;
        move_back   = 1'b0;
        sel_way     = '0;
        count_en    = 1'b0;
        write_tag   = 1'b0;
        clear_valid = 1'b0;
        unique case (op)
            OP_ACCESS: begin
                move_front = acc_hit;
                sel_way    = acc_way;
                count_en   = 1'b1;
            end
            OP_FILL: begin
                move_front = 1'b1;
                sel_way    = victim_way;
                write_tag  = 1'b1;
            end
            OP_REFRESH: begin
                move_front = 1'b1;
                sel_way    = upd_way;
            end
            OP_DROP: begin
                move_back   = 1'b1;
                sel_way     = upd_way;
                clear_valid = 1'b1;
            end
            OP_IDLE, OP_PROBE, OP_INV_MISS: begin
            end
            default: begin
            end
        endcase
    end

    // Tag and valid storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
        end else begin
            if (write_tag) begin
                valid_q[victim_way] <= 1'b1;
                tag_q[victim_way]   <= ins_addr[ADDR_W-1:OFF_W];
            end
            if (clear_valid) begin
                valid_q[upd_way] <= 1'b0;
            end
        end
    end

    // Results
    assign acc_rank     = rank[acc_way];
    assign hit          = acc_valid && acc_hit;
    assign hit_way      = acc_way;
    assign victim_way   = order[NUM_BLOCKS-1];
    assign victim_valid = valid_q[victim_way];

    for (genvar i = 0; i < NUM_SIZES; i++) begin : g_mask
        localparam int CAP = BASE_BLOCKS << i;
        assign hit_mask[i] = hit && (int'(acc_rank) < CAP);
    end

    lrus_stat_counters #(
        .NUM_SIZES (NUM_SIZES),
        .CNT_W     (CNT_W)
    ) u_stats (
        .clk          (clk),
        .rst_n        (rst_n),
        .count_en     (count_en),
        .hit_full     (acc_hit),
        .mask         (hit_mask),
        .hit_count    (hit_count),
        .miss_count   (miss_count),
        .access_count (access_count)
    );

endmodule

// File: rtl/lrus_tag_store_chk.sv
module lrus_tag_store_chk #(
    parameter int NUM_BLOCKS = 16,
    parameter int NUM_SIZES  = 3,
    parameter int IDX_W      = 4,
    parameter int CNT_W      = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_valid,
    input logic                  acc_probe,
    input logic                  ins_valid,
    input logic                  inv_valid,
    input logic                  hit,
    input logic [NUM_SIZES-1:0]  hit_mask,
    input logic [IDX_W-1:0]      victim_way,
    input logic                  victim_valid,
    input logic [CNT_W-1:0]      access_count,
    input logic [NUM_BLOCKS-1:0] acc_match,
    input logic                  upd_hit,
    input logic [IDX_W-1:0]      upd_way
);

    AST_MISS_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> hit_mask == '0); // R4

    AST_PROBE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_probe && !ins_valid && !inv_valid |=> $stable(access_count)); // R3

    AST_ACCESS_BUMPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_probe && !ins_valid && !inv_valid
        |=> access_count == CNT_W'($past(access_count) + CNT_W'(1))); // R9

    AST_DROP_TO_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && upd_hit |=> victim_way == $past(upd_way) && !victim_valid); // R8

    AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_match)); // R7

    AST_LOSER_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (ins_valid || inv_valid) |=> $stable(access_count)); // R10

endmodule

bind lrus_tag_store lrus_tag_store_chk #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .NUM_SIZES  (NUM_SIZES),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_probe    (acc_probe),
    .ins_valid    (ins_valid),
    .inv_valid    (inv_valid),
    .hit          (hit),
    .hit_mask     (hit_mask),
    .victim_way   (victim_way),
    .victim_valid (victim_valid),
    .access_count (access_count),
    .acc_match    (acc_match),
    .upd_hit      (upd_hit),
    .upd_way      (upd_way)
);

// File: tb/test_lrus_tag_store.sv
module test_lrus_tag_store;

    localparam int N     = 16;
    localparam int AW    = 32;
    localparam int NS    = 3;
    localparam int CW    = 16;
    localparam int IW    = 4;

    localparam logic [1:0] K_ACC = 2'd0;
    localparam logic [1:0] K_PRB = 2'd1;
    localparam logic [1:0] K_INS = 2'd2;
    localparam logic [1:0] K_INV = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] addr;
        logic        hit;
        logic [2:0]  mask;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{K_INS, 32'h040, 1'b0, 3'b000},
        '{K_INS, 32'h080, 1'b0, 3'b000},
        '{K_INS, 32'h0C0, 1'b0, 3'b000},
        '{K_INS, 32'h100, 1'b0, 3'b000},
        '{K_INS, 32'h140, 1'b0, 3'b000},
        '{K_ACC, 32'h17F, 1'b1, 3'b111},
        '{K_ACC, 32'h040, 1'b1, 3'b100},
        '{K_PRB, 32'h080, 1'b1, 3'b100},
        '{K_PRB, 32'h0A5, 1'b1, 3'b100},
        '{K_ACC, 32'h080, 1'b1, 3'b100},
        '{K_ACC, 32'h040, 1'b1, 3'b111},
        '{K_ACC, 32'h0C0, 1'b1, 3'b100},
        '{K_ACC, 32'h100, 1'b1, 3'b100},
        '{K_ACC, 32'h140, 1'b1, 3'b100},
        '{K_ACC, 32'h080, 1'b1, 3'b100},
        '{K_ACC, 32'h0C0, 1'b1, 3'b110},
        '{K_ACC, 32'h800, 1'b0, 3'b000},
        '{K_INV, 32'h140, 1'b0, 3'b000},
        '{K_ACC, 32'h140, 1'b0, 3'b000},
        '{K_ACC, 32'h100, 1'b1, 3'b110}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_probe = 1'b0;
    logic [AW-1:0]     acc_addr = '0;
    logic              ins_valid = 1'b0;
    logic [AW-1:0]     ins_addr = '0;
    logic              inv_valid = 1'b0;
    logic [AW-1:0]     inv_addr = '0;
    logic              hit;
    logic [IW-1:0]     hit_way;
    logic [NS-1:0]     hit_mask;
    logic [IW-1:0]     victim_way;
    logic              victim_valid;
    logic [(NS+1)*CW-1:0] hit_count;
    logic [(NS+1)*CW-1:0] miss_count;
    logic [CW-1:0]     access_count;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lrus_tag_store i_lrus_tag_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_probe    (acc_probe),
        .acc_addr     (acc_addr),
        .ins_valid    (ins_valid),
        .ins_addr     (ins_addr),
        .inv_valid    (inv_valid),
        .inv_addr     (inv_addr),
        .hit          (hit),
        .hit_way      (hit_way),
        .hit_mask     (hit_mask),
        .victim_way   (victim_way),
        .victim_valid (victim_valid),
        .hit_count    (hit_count),
        .miss_count   (miss_count),
        .access_count (access_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic idle_all();
        acc_valid = 1'b0;
        acc_probe = 1'b0;
        ins_valid = 1'b0;
        inv_valid = 1'b0;
    endtask

    // Drive one request at the falling edge, sample results before the rising edge.
    task automatic step(input logic [1:0] kind, input logic [AW-1:0] a,
                        output logic h, output logic [NS-1:0] m);
        @(negedge clk);
        idle_all();
        case (kind)
            K_ACC: begin acc_valid = 1'b1; acc_addr = a; end
            K_PRB: begin acc_valid = 1'b1; acc_probe = 1'b1; acc_addr = a; end
            K_INS: begin ins_valid = 1'b1; ins_addr = a; end
            default: begin inv_valid = 1'b1; inv_addr = a; end
        endcase
        #1;
        h = hit;
        m = hit_mask;
        @(posedge clk);
        #1;
        idle_all();
    endtask

    function automatic logic [CW-1:0] fld(input logic [(NS+1)*CW-1:0] bus, input int s);
        return bus[s*CW +: CW];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic          h;
        logic [NS-1:0] m;
        logic [IW-1:0] v0;
        int exp_hit [NS+1];
        int exp_miss [NS+1];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: reset state
        check(access_count == 0, "R11 access_count after reset", access_count, 0);
        check(victim_way == IW'(N-1) && !victim_valid, "R11 victim after reset",
              {victim_valid, victim_way}, N-1);
        check(hit_count == '0 && miss_count == '0, "R11 counters after reset", hit_count, 0);

        // Table: R1 offset ignored, R2 promotion, R3 probe, R4 masks, R6 insert
        for (int r = 0; r < NV; r++) begin
            step(VECS[r].kind, VECS[r].addr, h, m);
            if (VECS[r].kind == K_ACC || VECS[r].kind == K_PRB) begin
                check(h == VECS[r].hit && m == VECS[r].mask,
                      $sformatf("R1 R2 R3 R4 R6 table row %0d hit/mask", r),
                      {h, m}, {VECS[r].hit, VECS[r].mask});
            end
        end

        // R9: counters after the table
        exp_hit  = '{2, 4, 10, 10};
        exp_miss = '{10, 8, 2, 2};
        for (int s = 0; s <= NS; s++) begin
            check(fld(hit_count, s) == CW'(exp_hit[s]), $sformatf("R9 hit_count field %0d", s),
                  fld(hit_count, s), exp_hit[s]);
            check(fld(miss_count, s) == CW'(exp_miss[s]), $sformatf("R9 miss_count field %0d", s),
                  fld(miss_count, s), exp_miss[s]);
        end
        check(access_count == 12, "R9 access_count", access_count, 12);

        // R8: invalidated block (entry 11) sinks to the victim slot
        check(victim_way == 4'd11 && !victim_valid, "R8 invalidated entry becomes victim",
              {victim_valid, victim_way}, 11);

        // R10: insert beats access in the same cycle
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h100;
        ins_valid = 1'b1; ins_addr = 32'h900;
        @(posedge clk); #1; idle_all();
        check(access_count == 12, "R10 access ignored under insert", access_count, 12);
        step(K_PRB, 32'h900, h, m);
        check(h && m == 3'b111, "R6 R10 inserted block at MRU", {h, m}, 4'hF);

        // R10: invalidate beats insert
        @(negedge clk);
        inv_valid = 1'b1; inv_addr = 32'h900;
        ins_valid = 1'b1; ins_addr = 32'hA00;
        @(posedge clk); #1; idle_all();
        step(K_PRB, 32'h900, h, m);
        check(!h, "R8 R10 invalidated block misses", h, 0);
        step(K_PRB, 32'hA00, h, m);
        check(!h, "R10 losing insert ignored", h, 0);

        // R7: insert of a resident address
        v0 = victim_way;
        step(K_INS, 32'h0C0, h, m);
        check(victim_way == v0, "R7 victim unchanged on resident insert", victim_way, v0);
        step(K_PRB, 32'h0C0, h, m);
        check(h && m == 3'b111, "R7 resident insert promotes", {h, m}, 4'hF);

        // R12: result same cycle, counter after the edge
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h100;
        #1;
        check(hit && access_count == 12, "R12 combinational result, count not yet updated",
              {hit, access_count}, {1'b1, 16'd12});
        @(posedge clk); #1; idle_all();
        check(access_count == 13, "R12 count after edge", access_count, 13);

        // R5: fill all entries with new blocks, then evict the oldest
        for (int k = 1; k <= 16; k++) begin
            step(K_INS, 32'h1000 + 32'(k * 64), h, m);
        end
        check(victim_valid == 1'b1, "R5 victim valid when full", victim_valid, 1);
        step(K_INS, 32'h1000 + 32'(17 * 64), h, m);
        step(K_PRB, 32'h1000 + 32'(1 * 64), h, m);
        check(!h, "R5 LRU block evicted", h, 0);
        step(K_PRB, 32'h0C0, h, m);
        check(!h, "R5 old block evicted", h, 0);
        // R4 boundaries: block k sits at position 17-k
        for (int k = 2; k <= 17; k++) begin
            int pos;
            logic [NS-1:0] em;
            pos = 17 - k;
            em = {pos < 8, pos < 4, pos < 2};
            step(K_PRB, 32'h1000 + 32'(k * 64), h, m);
            check(h && m == em, $sformatf("R4 mask at position %0d", pos), {h, m}, {1'b1, em});
        end

        // R11: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(access_count == 0 && hit_count == '0 && miss_count == '0,
              "R11 counters cleared", access_count, 0);
        check(victim_way == IW'(N-1) && !victim_valid, "R11 victim restored",
              {victim_valid, victim_way}, N-1);
        step(K_PRB, 32'h1000 + 32'(17 * 64), h, m);
        check(!h, "R11 entries invalid after reset", h, 0);

        summary();
        $finish;
    end

endmodule